// File: doc/BRIEF.md
# Receive FIFO Frame Packer

This block sits behind a receive MAC and stores each received frame in a 32-bit word FIFO that a host drains through one data port. A frame enters as a byte stream: a valid strobe, a data byte, a last-byte flag, and two error flags, one for a bad CRC and one for a misaligned frame, both sampled with the last byte. The block packs the bytes into words. Once the frame is complete it places two leading words in front of the payload: a fixed marker word and a header that holds the byte length and a status field.

The host reads words one at a time while `rd_valid` is high. It takes the length from the header to learn how many payload words follow. A counter reports how many complete frames are waiting. The host can force that counter to zero. A FIFO reset request empties the store, and the block signals it as busy until the reset has finished. A frame that cannot fit whole in the free space is discarded, so a partly stored frame is never visible to the host. A programmable maximum length marks frames that are too long.

Top module: `rx_frame_packer`

## Requirements
- R1: The first word of every stored frame is the constant 0x0143414D.
- R2: The second word of every stored frame holds the byte count of the frame in bits 15:0, including the check-sequence bytes. It holds the status in bits 31:16, and bits 31:24 are zero.
- R3: The status bits sit in the header word as follows:
  - bit 20 (CRC error) copies `in_err_crc` from the last byte.
  - bit 22 (alignment error) copies `in_err_aln` from the last byte.
  - bit 21 (length error) is set when the byte count exceeds `cfg_max_len`.
  - bit 23 (frame good) is set exactly when bits 22:20 are all clear.
- R4: The payload follows the header in ceil(length/4) words. Byte k of the frame sits in word k/4, bits 8*(k%4)+7 : 8*(k%4). Unused bytes of the last word are zero. A word stays on `rd_data` while `rd_en` is low.
- R5: `frame_cnt` rises by one in the cycle after the clock edge that takes the last byte of a stored frame. It falls by one at the edge where the host reads a header word. A read when the counter is already zero leaves it at zero.
- R6: A `cnt_clr` pulse makes `frame_cnt` zero after the next edge. This holds even if a commit or a header read happens at the same edge. Stored words are not affected.
- R7: A `fifo_rst_req` pulse starts a reset:
  - `fifo_rst_busy` is high for the next RST_CYCLES cycles.
  - From the request edge on, the FIFO is empty and `frame_cnt` is zero.
  - `rd_valid` is low while busy.
  - A frame in progress at the request is discarded, up to and including its last byte.
- R8: The maximum-length register `cfg_max_len` resets to 0x600 and takes `cfg_max_len_wdata` on a `cfg_we` edge.
- R9: A frame whose words do not all fit in the free space is dropped entirely. `frame_cnt` does not change, and later frames that fit are stored normally.
- R10: `rd_en` while `rd_valid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Receive byte strobe |
| in_data | input | 8 | Receive byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_err_crc | input | 1 | CRC error flag, sampled with the last byte |
| in_err_aln | input | 1 | Alignment error flag, sampled with the last byte |
| rd_en | input | 1 | Host consumes the word on `rd_data` |
| rd_data | output | 32 | Word at the head of the FIFO |
| rd_valid | output | 1 | A committed word is available |
| frame_cnt | output | $clog2(DEPTH)+1 | Number of complete frames waiting |
| cnt_clr | input | 1 | Forces the frame counter to zero |
| fifo_rst_req | input | 1 | Requests a FIFO reset |
| fifo_rst_busy | output | 1 | A FIFO reset is in progress |
| cfg_we | input | 1 | Write strobe for the maximum length |
| cfg_max_len_wdata | input | 16 | New maximum length |
| cfg_max_len | output | 16 | Current maximum length |

## Verification
The bench targets these corner cases:
- **One-byte and odd-length frames.** A packer that mishandles them would mis-pad or drop the last partial word.
- **Header reads at the same time as new commits, and reads while bytes stream in.** A faulty counter would skip or double a step here.
- **A frame that overflows the remaining space, followed by one that still fits.** A design that keeps partial words or fails to roll back its write pointer would corrupt the next frame's marker.
- **A FIFO reset in the middle of a frame, whose bytes keep arriving after busy ends.** A design that resumed packing there would commit a stray fragment.
- **Length limits exactly at and one above `cfg_max_len`.** These expose an off-by-one in the length-error bit.

// File: rtl/rxfp_pkg.sv
package rxfp_pkg;

    localparam logic [31:0] MARKER_WORD = 32'h0143_414D;

    typedef enum logic [1:0] {
        W_IDLE,
        W_RECV,
        W_DROP
    } wr_state_e;

    typedef enum logic [1:0] {
        R_MARK,
        R_HDR,
        R_DATA
    } rd_phase_e;

    // Status byte lives in header bits 23:16; upper status byte is zero.
    function automatic logic [31:0] build_header(input logic [15:0] nbytes,
                                                 input logic        crc_bad,
                                                 input logic        aln_bad,
                                                 input logic        len_bad);
        logic [7:0] st;
        st = {~(crc_bad | aln_bad | len_bad), aln_bad, len_bad, crc_bad, 4'h0};
        return {8'h00, st, nbytes};
    endfunction

    function automatic logic [14:0] payload_words(input logic [15:0] nbytes);
        logic [16:0] sum;
        sum = {1'b0, nbytes} + 17'd3;
        return sum[16:2];
    endfunction

endpackage

// File: rtl/rxfp_mem.sv
module rxfp_mem #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          pay_we,
    input  logic [AW-1:0] pay_addr,
    input  logic [31:0]   pay_data,
    input  logic          mrk_we,
    input  logic [AW-1:0] mrk_addr,
    input  logic [31:0]   mrk_data,
    input  logic          hdr_we,
    input  logic [AW-1:0] hdr_addr,
    input  logic [31:0]   hdr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_word
);

    logic [31:0] word_q [DEPTH];

    // The three write addresses are always distinct when enabled together.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (pay_we && pay_addr == AW'(i)) begin
                word_q[i] <= pay_data;
            end else if (mrk_we && mrk_addr == AW'(i)) begin
                word_q[i] <= mrk_data;
            end else if (hdr_we && hdr_addr == AW'(i)) begin
                word_q[i] <= hdr_data;
            end
        end
    end

    assign rd_word = word_q[rd_addr];

endmodule

// File: rtl/rxfp_writer.sv
module rxfp_writer
    import rxfp_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic          in_err_crc,
    input  logic          in_err_aln,
    input  logic [15:0]   max_len,
    input  logic [PW-1:0] rptr,
    output logic          pay_we,
    output logic [AW-1:0] pay_addr,
    output logic [31:0]   pay_data,
    output logic          mrk_we,
    output logic [AW-1:0] mrk_addr,
    output logic          hdr_we,
    output logic [AW-1:0] hdr_addr,
    output logic [31:0]   hdr_data,
    output logic          commit,
    output logic [PW-1:0] commit_ptr
);

    typedef struct packed {
        wr_state_e     st;
        logic [31:0]   acc;
        logic [1:0]    nb;
        logic [15:0]   len;
        logic [PW-1:0] base;
        logic [PW-1:0] wp;
        logic [PW-1:0] cwp;
    } wr_regs_t;

    wr_regs_t r_q, r_d;

    logic [PW-1:0] cur_base, cur_wp, used;
    logic [31:0]   cur_acc, acc_new;
    logic [1:0]    cur_nb;
    logic [15:0]   cur_len, len_new;
    logic          fresh, flush, room;

    always_comb begin
        r_d      = r_q;
        pay_we   = 1'b0;
        pay_addr = '0;
        pay_data = '0;
        mrk_we   = 1'b0;
        mrk_addr = '0;
        hdr_we   = 1'b0;
        hdr_addr = '0;
        hdr_data = '0;
        commit   = 1'b0;

        fresh    = (r_q.st == W_IDLE);
        cur_base = fresh ? r_q.cwp : r_q.base;
        cur_wp   = fresh ? r_q.cwp + PW'(2) : r_q.wp;
        cur_acc  = fresh ? 32'h0 : r_q.acc;
        cur_nb   = fresh ? 2'd0 : r_q.nb;
        cur_len  = fresh ? 16'd0 : r_q.len;
        acc_new  = cur_acc;
        acc_new[{cur_nb, 3'b000} +: 8] = in_data;
        len_new  = cur_len + 16'd1;
        flush    = (cur_nb == 2'd3) || in_last;
        used     = cur_wp - rptr;
        room     = (used < PW'(DEPTH));

        if (clr) begin
            r_d.cwp = '0;
            if (in_valid) begin
                r_d.st = in_last ? W_IDLE : W_DROP;
            end else begin
                r_d.st = fresh ? W_IDLE : W_DROP;
            end
        end else if (r_q.st == W_DROP) begin
            if (in_valid && in_last) begin
                r_d.st = W_IDLE;
            end
        end else if (in_valid) begin
            if (flush && !room) begin
                r_d.st = in_last ? W_IDLE : W_DROP;
            end else begin
                r_d.base = cur_base;
                r_d.len  = len_new;
                if (flush) begin
                    pay_we   = 1'b1;
                    pay_addr = cur_wp[AW-1:0];
                    pay_data = acc_new;
                    r_d.wp   = cur_wp + PW'(1);
                    r_d.acc  = '0;
                    r_d.nb   = 2'd0;
                end else begin
                    r_d.wp   = cur_wp;
                    r_d.acc  = acc_new;
                    r_d.nb   = cur_nb + 2'd1;
                end
                if (in_last) begin
                    mrk_we   = 1'b1;
                    mrk_addr = cur_base[AW-1:0];
                    hdr_we   = 1'b1;
                    hdr_addr = cur_base[AW-1:0] + AW'(1);
                    hdr_data = build_header(len_new, in_err_crc, in_err_aln,
                                            len_new > max_len);
                    commit   = 1'b1;
                    r_d.cwp  = cur_wp + PW'(1);
                    r_d.st   = W_IDLE;
                end else begin
                    r_d.st   = W_RECV;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: W_IDLE, acc: '0, nb: '0, len: '0, base: '0, wp: '0, cwp: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign commit_ptr = r_q.cwp;

endmodule

// File: rtl/rxfp_reader.sv
module rxfp_reader
    import rxfp_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          busy,
    input  logic          cnt_clr,
    input  logic          commit,
    input  logic [PW-1:0] commit_ptr,
    input  logic          rd_en,
    input  logic [15:0]   head_len,
    output logic [PW-1:0] rptr,
    output logic          rd_valid,
    output logic [PW-1:0] frame_cnt
);

    typedef struct packed {
        rd_phase_e     ph;
        logic [14:0]   rem;
        logic [PW-1:0] rp;
        logic [PW-1:0] cnt;
    } rd_regs_t;

    rd_regs_t r_q, r_d;
    logic     fire, hdr_take;

    always_comb begin
        r_d      = r_q;
        rd_valid = (r_q.rp != commit_ptr) && !busy;
        fire     = rd_en && rd_valid;
        hdr_take = 1'b0;

        if (clr) begin
            r_d.ph  = R_MARK;
            r_d.rem = '0;
            r_d.rp  = '0;
            r_d.cnt = '0;
        end else begin
            if (fire) begin
                r_d.rp = r_q.rp + PW'(1);
                unique case (r_q.ph)
                    R_MARK: r_d.ph = R_HDR;
                    R_HDR: begin
                        hdr_take = 1'b1;
                        r_d.rem  = payload_words(head_len);
                        r_d.ph   = R_DATA;
                    end
                    default: begin
                        r_d.rem = r_q.rem - 15'd1;
                        if (r_q.rem == 15'd1) begin
                            r_d.ph = R_MARK;
                        end
                    end
                endcase
            end
            if (cnt_clr) begin
                r_d.cnt = '0;
            end else begin
                r_d.cnt = r_q.cnt - PW'(hdr_take && (r_q.cnt != '0)) + PW'(commit);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ph: R_MARK, rem: '0, rp: '0, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rptr      = r_q.rp;
    assign frame_cnt = r_q.cnt;

endmodule

// File: rtl/rx_frame_packer.sv
module rx_frame_packer
    import rxfp_pkg::*;
#(
    parameter int          DEPTH       = 64,
    parameter int          RST_CYCLES  = 4,
    parameter logic [15:0] MAXLEN_INIT = 16'h0600
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [7:0]               in_data,
    input  logic                     in_last,
    input  logic                     in_err_crc,
    input  logic                     in_err_aln,
    input  logic                     rd_en,
    output logic [31:0]              rd_data,
    output logic                     rd_valid,
    output logic [$clog2(DEPTH):0]   frame_cnt,
    input  logic                     cnt_clr,
    input  logic                     fifo_rst_req,
    output logic                     fifo_rst_busy,
    input  logic                     cfg_we,
    input  logic [15:0]              cfg_max_len_wdata,
    output logic [15:0]              cfg_max_len
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int RW = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [RW-1:0] rcnt;
        logic [15:0]   maxlen;
    } top_regs_t;

    top_regs_t t_q, t_d;
    logic      clr;

    always_comb begin
        t_d = t_q;
        if (fifo_rst_req) begin
            t_d.rcnt = RW'(RST_CYCLES);
        end else if (t_q.rcnt != '0) begin
            t_d.rcnt = t_q.rcnt - RW'(1);
        end
        if (cfg_we) begin
            t_d.maxlen = cfg_max_len_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{rcnt: '0, maxlen: MAXLEN_INIT};
        end else begin
            t_q <= t_d;
        end
    end

    assign fifo_rst_busy = (t_q.rcnt != '0);
    assign clr           = fifo_rst_req || fifo_rst_busy;
    assign cfg_max_len   = t_q.maxlen;

    logic          pay_we, mrk_we, hdr_we, commit;
    logic [AW-1:0] pay_addr, mrk_addr, hdr_addr;
    logic [31:0]   pay_data, hdr_data;
    logic [PW-1:0] commit_ptr, rptr;

    rxfp_writer #(.DEPTH(DEPTH)) u_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_err_crc (in_err_crc),
        .in_err_aln (in_err_aln),
        .max_len    (t_q.maxlen),
        .rptr       (rptr),
        .pay_we     (pay_we),
        .pay_addr   (pay_addr),
        .pay_data   (pay_data),
        .mrk_we     (mrk_we),
        .mrk_addr   (mrk_addr),
        .hdr_we     (hdr_we),
        .hdr_addr   (hdr_addr),
        .hdr_data   (hdr_data),
        .commit     (commit),
        .commit_ptr (commit_ptr)
    );

    rxfp_mem #(.DEPTH(DEPTH)) u_mem (
        .clk      (clk),
        .pay_we   (pay_we),
        .pay_addr (pay_addr),
        .pay_data (pay_data),
        .mrk_we   (mrk_we),
        .mrk_addr (mrk_addr),
        .mrk_data (MARKER_WORD),
        .hdr_we   (hdr_we),
        .hdr_addr (hdr_addr),
        .hdr_data (hdr_data),
        .rd_addr  (rptr[AW-1:0]),
        .rd_word  (rd_data)
    );

    rxfp_reader #(.DEPTH(DEPTH)) u_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .busy       (fifo_rst_busy),
        .cnt_clr    (cnt_clr),
        .commit     (commit),
        .commit_ptr (commit_ptr),
        .rd_en      (rd_en),
        .head_len   (rd_data[15:0]),
        .rptr       (rptr),
        .rd_valid   (rd_valid),
        .frame_cnt  (frame_cnt)
    );

endmodule

// File: rtl/rxfp_chk.sv
module rxfp_chk #(
    parameter int CW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic          rd_valid,
    input logic [31:0]   rd_data,
    input logic [CW-1:0] frame_cnt,
    input logic          cnt_clr,
    input logic          fifo_rst_req,
    input logic          fifo_rst_busy,
    input logic          cfg_we,
    input logic [15:0]   cfg_max_len
);

    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_en && !fifo_rst_req |=> rd_valid && $stable(rd_data)); // R4

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr && !fifo_rst_req && !fifo_rst_busy |=>
            (frame_cnt == $past(frame_cnt)) ||
            (frame_cnt == $past(frame_cnt) + 1'b1) ||
            (frame_cnt + 1'b1 == $past(frame_cnt))); // R5

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> frame_cnt == '0); // R6

    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst_req |=> fifo_rst_busy); // R7

    AST_BUSY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst_busy |-> frame_cnt == '0 && !rd_valid); // R7

    AST_MAXLEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_max_len)); // R8

endmodule

bind rx_frame_packer rxfp_chk #(.CW($clog2(DEPTH) + 1)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_en         (rd_en),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .frame_cnt     (frame_cnt),
    .cnt_clr       (cnt_clr),
    .fifo_rst_req  (fifo_rst_req),
    .fifo_rst_busy (fifo_rst_busy),
    .cfg_we        (cfg_we),
    .cfg_max_len   (cfg_max_len)
);

// File: tb/rx_frame_packer_tb.sv
module rx_frame_packer_tb_top;

    localparam int DEPTH   = 64;
    localparam int RST_CYC = 4;
    localparam int CW      = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_last = 1'b0, in_err_crc = 1'b0, in_err_aln = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          rd_en = 1'b0, cnt_clr = 1'b0, fifo_rst_req = 1'b0, cfg_we = 1'b0;
    logic [15:0]   cfg_max_len_wdata = 16'h0;
    logic [31:0]   rd_data;
    logic          rd_valid, fifo_rst_busy;
    logic [CW-1:0] frame_cnt;
    logic [15:0]   cfg_max_len;

    always #2 clk = ~clk;

    rx_frame_packer #(.DEPTH(DEPTH), .RST_CYCLES(RST_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_err_crc(in_err_crc), .in_err_aln(in_err_aln),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .frame_cnt(frame_cnt),
        .cnt_clr(cnt_clr), .fifo_rst_req(fifo_rst_req), .fifo_rst_busy(fifo_rst_busy),
        .cfg_we(cfg_we), .cfg_max_len_wdata(cfg_max_len_wdata), .cfg_max_len(cfg_max_len)
    );

    int checks = 0;
    int fails  = 0;

    // Reference model state
    logic [31:0] mq[$];
    int          mt[$];      // 0 marker, 1 header, 2 payload
    int          m_cnt = 0, m_rcnt = 0, m_maxlen = 16'h0600;
    int          b_state = 0; // 0 idle, 1 receiving, 2 dropping
    int          b_len = 0, b_nb = 0;
    logic [31:0] b_acc = 0;
    logic [31:0] b_words[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int qsz;
        bit busy, clr, fire, commit, dec, lerr;
        logic [7:0] st;
        qsz    = mq.size();
        busy   = (m_rcnt != 0);
        clr    = fifo_rst_req || busy;
        fire   = rd_en && qsz > 0 && !busy;
        commit = 0;
        dec    = 0;
        if (clr) begin
            if (in_valid) b_state = in_last ? 0 : 2;
            else if (b_state != 0) b_state = 2;
            mq.delete(); mt.delete(); m_cnt = 0;
        end else begin
            if (b_state == 2) begin
                if (in_valid && in_last) b_state = 0;
            end else if (in_valid) begin
                if (b_state == 0) begin
                    b_len = 0; b_nb = 0; b_acc = 0; b_words.delete();
                end
                b_acc = b_acc | (32'(in_data) << (8 * b_nb));
                b_len++;
                b_nb++;
                if (b_nb == 4 || in_last) begin
                    if (qsz + 2 + b_words.size() + 1 > DEPTH) begin
                        b_state = in_last ? 0 : 2;
                    end else begin
                        b_words.push_back(b_acc);
                        b_acc = 0; b_nb = 0;
                        if (in_last) begin commit = 1; b_state = 0; end
                        else b_state = 1;
                    end
                end else begin
                    b_state = 1;
                end
            end
            if (fire) begin
                if (mt[0] == 1) dec = 1;
                void'(mq.pop_front()); void'(mt.pop_front());
            end
            if (commit) begin
                lerr = (b_len > m_maxlen);
                st = {~(in_err_crc | in_err_aln | lerr), in_err_aln, lerr, in_err_crc, 4'h0};
                mq.push_back(32'h0143414D); mt.push_back(0);
                mq.push_back({8'h00, st, 16'(b_len)}); mt.push_back(1);
                foreach (b_words[k]) begin mq.push_back(b_words[k]); mt.push_back(2); end
            end
            if (cnt_clr) m_cnt = 0;
            else begin
                if (dec && m_cnt > 0) m_cnt--;
                if (commit) m_cnt++;
            end
        end
        if (fifo_rst_req) m_rcnt = RST_CYC;
        else if (m_rcnt > 0) m_rcnt--;
        if (cfg_we) m_maxlen = cfg_max_len_wdata;
    endtask

    task automatic compare();
        bit ev;
        ev = (mq.size() > 0) && (m_rcnt == 0);
        chk(rd_valid === ev, "R10", "rd_valid", 32'(rd_valid), 32'(ev));
        if (ev && rd_valid) begin
            if (mt[0] == 0)      chk(rd_data === mq[0], "R1", "marker word", rd_data, mq[0]);
            else if (mt[0] == 1) chk(rd_data === mq[0], "R2 R3", "header word", rd_data, mq[0]);
            else                 chk(rd_data === mq[0], "R4", "payload word", rd_data, mq[0]);
        end
        chk(frame_cnt === CW'(m_cnt), "R5", "frame_cnt", 32'(frame_cnt), 32'(m_cnt));
        chk(fifo_rst_busy === (m_rcnt != 0), "R7", "fifo_rst_busy", 32'(fifo_rst_busy), 32'(m_rcnt != 0));
        chk(cfg_max_len === 16'(m_maxlen), "R8", "cfg_max_len", 32'(cfg_max_len), 32'(m_maxlen));
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        model_step();
        compare();
    endtask

    task automatic send_frame(input int len, input bit crc, input bit aln,
                              input int seed, input bit gaps, input int rst_at);
        for (int i = 0; i < len; i++) begin
            if (gaps && (i % 3 == 1)) begin
                in_valid = 0; in_last = 0; in_err_crc = 0; in_err_aln = 0;
                cyc();
            end
            in_valid     = 1;
            in_data      = 8'(seed + i * 7);
            in_last      = (i == len - 1);
            in_err_crc   = crc && (i == len - 1);
            in_err_aln   = aln && (i == len - 1);
            fifo_rst_req = (i == rst_at);
            cyc();
            fifo_rst_req = 0;
        end
        in_valid = 0; in_last = 0; in_err_crc = 0; in_err_aln = 0;
    endtask

    task automatic drain();
        rd_en = 1;
        while (mq.size() > 0 || m_rcnt != 0) cyc();
        rd_en = 0;
        cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // Reset state: R7 R8
        chk(rd_valid === 1'b0, "R7", "reset rd_valid", 32'(rd_valid), 0);
        chk(frame_cnt === '0, "R5", "reset frame_cnt", 32'(frame_cnt), 0);
        chk(fifo_rst_busy === 1'b0, "R7", "reset busy", 32'(fifo_rst_busy), 0);
        chk(cfg_max_len === 16'h0600, "R8", "reset max length", 32'(cfg_max_len), 32'h600);
        rst_n = 1;
        cyc(); cyc();

        // Basic frame: R1 R2 R4
        send_frame(64, 0, 0, 1, 0, -1);
        cyc();
        chk(frame_cnt === 1, "R5", "count after one frame", 32'(frame_cnt), 1);
        drain();

        // Odd lengths and status flags: R3 R4
        send_frame(1, 1, 0, 9, 0, -1);
        send_frame(5, 0, 1, 33, 1, -1);
        send_frame(7, 1, 1, 77, 1, -1);
        cyc();
        chk(frame_cnt === 3, "R5", "count after three frames", 32'(frame_cnt), 3);
        drain();

        // Length limit boundaries: R3 R8
        cfg_max_len_wdata = 16'd20; cfg_we = 1; cyc(); cfg_we = 0; cyc();
        chk(cfg_max_len === 16'd20, "R8", "max length written", 32'(cfg_max_len), 20);
        send_frame(21, 0, 0, 5, 0, -1);
        send_frame(20, 0, 0, 6, 0, -1);
        drain();
        cfg_max_len_wdata = 16'h0600; cfg_we = 1; cyc(); cfg_we = 0;

        // Reads while frames stream in: R5
        rd_en = 1;
        send_frame(30, 0, 0, 11, 1, -1);
        send_frame(13, 0, 0, 12, 0, -1);
        send_frame(2, 0, 0, 13, 0, -1);
        drain();

        // Counter clear: R6
        send_frame(10, 0, 0, 21, 0, -1);
        send_frame(10, 0, 0, 22, 0, -1);
        cnt_clr = 1; cyc(); cnt_clr = 0;
        chk(frame_cnt === 0, "R6", "count after clear", 32'(frame_cnt), 0);
        chk(rd_valid === 1'b1, "R6", "words kept after clear", 32'(rd_valid), 1);
        drain();
        chk(frame_cnt === 0, "R5", "count saturates at zero", 32'(frame_cnt), 0);

        // Reads on empty: R10
        rd_en = 1;
        repeat (5) cyc();
        rd_en = 0;
        chk(rd_valid === 1'b0, "R10", "empty read ignored", 32'(rd_valid), 0);
        send_frame(8, 0, 0, 40, 0, -1);
        drain();

        // Overflow drops a whole frame: R9
        send_frame(200, 0, 0, 50, 0, -1);
        send_frame(60, 0, 0, 51, 0, -1);
        cyc();
        chk(frame_cnt === 1, "R9", "oversized frame dropped", 32'(frame_cnt), 1);
        send_frame(20, 0, 0, 52, 0, -1);
        cyc();
        chk(frame_cnt === 2, "R9", "later frame stored", 32'(frame_cnt), 2);
        drain();

        // FIFO reset in the middle of a frame: R7
        send_frame(12, 0, 0, 60, 0, -1);
        send_frame(16, 0, 0, 61, 0, 5);
        cyc();
        chk(frame_cnt === 0, "R7", "count after fifo reset", 32'(frame_cnt), 0);
        chk(rd_valid === 1'b0, "R7", "fifo empty after reset", 32'(rd_valid), 0);
        send_frame(9, 0, 1, 62, 0, -1);
        cyc();
        chk(frame_cnt === 1, "R7", "frame after reset stored", 32'(frame_cnt), 1);
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule